// File: doc/BRIEF.md
# CAM Priority Match Resolver

This block sits behind the compare logic of a small content-addressable memory. It takes the per-entry hit vector that one compare produces and turns it into a highest-priority match address, a hit flag and a more-than-one-hit flag. Priority goes to the lowest entry index. The block keeps its own copy of the hit vector. A step command removes the current winner from that copy, so the remaining hits can be visited one at a time in priority order. When the last one has been removed, a sticky exhausted flag is raised.

The block also owns the 64-bit comparand register and a file of eight mask registers. A move command reads the winning entry through a synchronous array read port and merges it into the comparand. Only the comparand bits whose selected mask bit is 0 take the entry's value. Mask register 0 always reads as zero, so selecting it copies the whole word. During a move the block releases its validity-bus drive enable. Cascading is reduced to one input, `prio_in`, which says that a higher-priority device still holds a hit. While it is high, step commands leave this block's state alone. `prio_out` passes the chain on to the next device.

A controller with three states sequences the commands:
- ST_IDLE accepts commands.
- ST_FETCH drives the array read.
- ST_MERGE writes the returned word into the comparand.

The transitions are:
- ST_IDLE goes to ST_FETCH on an accepted move while a hit is held.
- ST_FETCH always goes to ST_MERGE.
- ST_MERGE always returns to ST_IDLE.
- Every other case stays in ST_IDLE.

Top module: `cam_match_resolver`

## Requirements
- R1: After reset the following hold: `hit`=0, `multi`=0, `exhausted`=0, `hpm_addr`=0, `comparand`=0, `rd_en`=0, `vbus_oe`=1, `prio_out`=`prio_in`.
- R2: `op_code` encodings are 00 nop, 01 compare, 10 step and 11 move. A compare accepted at a clock edge loads `match_vec` as the held vector. From the next cycle, `hit` shows that the held vector is non-zero, `multi` shows that it has two or more set bits, and `hpm_addr` is the index of its lowest set bit.
- R3: An accepted step with `prio_in` low clears the lowest set bit of the held vector. `hpm_addr` then moves to the next lowest set bit, if one remains.
- R4: A step that clears the last held bit sets `exhausted` to 1 and `hit` to 0, and leaves `hpm_addr` unchanged. A later step changes nothing. A compare with an all-zero vector also leaves `hpm_addr` unchanged.
- R5: A compare clears `exhausted` and replaces the held vector completely.
- R6: While `prio_in` is 1, a step leaves the held vector, `hpm_addr` and the flags unchanged. `prio_out` equals `prio_in` OR `hit`.
- R7: A move accepted while `hit`=1 drives `rd_en`=1 with `rd_addr`=`hpm_addr` in the next cycle. The array returns `rd_data` one cycle later, and `comparand` shows the merged value in the third cycle after the command edge.
- R8: A move with `op_mask_sel`=s updates `comparand` bit i to the entry's bit i only where bit i of mask register s is 0. Where the mask bit is 1, the old comparand bit is kept.
- R9: Mask registers 1 to 7 are written by `mask_wr_en`/`mask_wr_sel`/`mask_wr_data`. Writes to register 0 are ignored, and register 0 always acts as all-zero.
- R10: `vbus_oe` is 0 in both cycles of a move (the fetch and merge cycles) and 1 otherwise.
- R11: A move with `hit`=0 does nothing: there is no read, `vbus_oe` stays 1 and `comparand` is unchanged.
- R12: Commands presented while a move is in progress are ignored.
- R13: `cmp_wr_en` loads `cmp_wr_data` into `comparand` on the next edge. In a merge cycle, the merge takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Command present this cycle |
| op_code | input | 2 | Command: 00 nop, 01 compare, 10 step, 11 move |
| op_mask_sel | input | 3 | Mask register used by a move |
| match_vec | input | 16 | Per-entry hit vector of the current compare |
| prio_in | input | 1 | A higher-priority device still holds a hit |
| cmp_wr_en | input | 1 | Load the comparand |
| cmp_wr_data | input | 64 | Comparand load value |
| mask_wr_en | input | 1 | Write a mask register |
| mask_wr_sel | input | 3 | Mask register written |
| mask_wr_data | input | 64 | Mask write value |
| rd_data | input | 64 | Array word, valid one cycle after `rd_en` |
| rd_en | output | 1 | Array read strobe |
| rd_addr | output | 4 | Array read address |
| comparand | output | 64 | Comparand register |
| hpm_addr | output | 4 | Highest-priority match address |
| hit | output | 1 | Held vector non-zero |
| multi | output | 1 | Held vector has two or more bits |
| exhausted | output | 1 | Last hit consumed by a step |
| prio_out | output | 1 | Priority chain to lower device |
| vbus_oe | output | 1 | Validity-bus drive enable |

## Verification
The step walk runs over three kinds of hit vector:
- Every one-hot vector shows that `hpm_addr` tracks a single bit. The first step must then raise `exhausted`.
- Every two-hot vector shows whether the encoder picks the lower of two bits and whether the clear removes only that bit.
- Pseudo-random dense vectors, plus all-zero and all-one, cover long walks and the case where the address is held.

Moves are tried with each of the eight mask selects over fixed distinct masks. This separates copying bits where the mask is 0 from copying where it is 1, and checks that register 0 stays zero after a write to it. Separate runs cover a blocked priority chain, a move with no hit, and commands that arrive in the middle of a move.

// File: rtl/cam_res_pkg.sv
package cam_res_pkg;
    typedef enum logic [1:0] {
        OP_NOP     = 2'b00,
        OP_COMPARE = 2'b01,
        OP_NEXT    = 2'b10,
        OP_MOVE    = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_FETCH = 2'b01,
        ST_MERGE = 2'b10
    } state_e;
endpackage

// File: rtl/cam_res_lowest.sv
module cam_res_lowest #(
    parameter int N  = 16,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Scan from the top so the lowest set index wins.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
        any = |vec;
    end
endmodule

// File: rtl/cam_res_tracker.sv
module cam_res_tracker #(
    parameter int ENTRIES = 16,
    parameter int IW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [ENTRIES-1:0] vec_in,
    input  logic               step,
    output logic [IW-1:0]      hpm,
    output logic               hit,
    output logic               multi,
    output logic               exhausted
);
    logic [ENTRIES-1:0] held;
    logic [ENTRIES-1:0] held_nxt;
    logic [ENTRIES-1:0] held_pop;
    logic [IW-1:0]      nxt_idx;
    logic               nxt_any;

    assign held_pop = held & (held - ENTRIES'(1));

    always_comb begin
        held_nxt = held;
        if (load)      held_nxt = vec_in;
        else if (step) held_nxt = held_pop;
    end

    cam_res_lowest #(.N(ENTRIES), .IW(IW)) u_enc (
        .vec (held_nxt),
        .idx (nxt_idx),
        .any (nxt_any)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held      <= '0;
            hpm       <= '0;
            exhausted <= 1'b0;
        end else begin
            held <= held_nxt;
            if ((load || step) && nxt_any) hpm <= nxt_idx;
            if (load)                              exhausted <= 1'b0;
            else if (step && (|held) && !nxt_any)  exhausted <= 1'b1;
        end
    end

    assign hit   = |held;
    assign multi = |held_pop;

    // R2: the reported address always names a bit that is still held
    p_hpm_points_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> held[hpm]);

    // R3: a step on a non-empty vector removes exactly one bit
    p_step_pops_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && hit) |=> ($countones(held) + 1 == $countones($past(held))));

    // R4: a step with at most one bit left keeps the address
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !multi) |=> $stable(hpm));

    // R5: a compare always clears the exhausted state
    p_compare_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !exhausted);
endmodule

// File: rtl/cam_res_mask_file.sv
module cam_res_mask_file #(
    parameter int REGS = 8,
    parameter int W    = 64,
    parameter int SW   = (REGS > 1) ? $clog2(REGS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_sel,
    input  logic [W-1:0]  wr_data,
    input  logic [SW-1:0] rd_sel,
    output logic [W-1:0]  rd_mask
);
    logic [REGS-1:0][W-1:0] bank;

    for (genvar r = 0; r < REGS; r++) begin : g_reg
        if (r == 0) begin : g_zero
            assign bank[r] = '0;
        end else begin : g_store
            logic [W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                             q <= '0;
                else if (wr_en && wr_sel == SW'(r))     q <= wr_data;
            end
            assign bank[r] = q;
        end
    end

    assign rd_mask = bank[rd_sel];

    // R9: selecting register 0 yields no masking, whatever was written
    p_reg0_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == '0) |-> (rd_mask == '0));
endmodule

// File: rtl/cam_match_resolver.sv
module cam_match_resolver
    import cam_res_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int WIDTH   = 64,
    parameter int MREGS   = 8,
    localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int SW     = (MREGS > 1) ? $clog2(MREGS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [1:0]         op_code,
    input  logic [SW-1:0]      op_mask_sel,
    input  logic [ENTRIES-1:0] match_vec,
    input  logic               prio_in,
    input  logic               cmp_wr_en,
    input  logic [WIDTH-1:0]   cmp_wr_data,
    input  logic               mask_wr_en,
    input  logic [SW-1:0]      mask_wr_sel,
    input  logic [WIDTH-1:0]   mask_wr_data,
    input  logic [WIDTH-1:0]   rd_data,
    output logic               rd_en,
    output logic [IW-1:0]      rd_addr,
    output logic [WIDTH-1:0]   comparand,
    output logic [IW-1:0]      hpm_addr,
    output logic               hit,
    output logic               multi,
    output logic               exhausted,
    output logic               prio_out,
    output logic               vbus_oe
);
    state_e          state, state_nxt;
    op_e             op;
    logic            accept;
    logic            do_load;
    logic            do_step;
    logic            do_move;
    logic [SW-1:0]   mask_sel_q;
    logic [WIDTH-1:0] mask_q;

    assign op      = op_e'(op_code);
    assign accept  = op_valid && (state == ST_IDLE);
    assign do_load = accept && (op == OP_COMPARE);
    assign do_step = accept && (op == OP_NEXT) && !prio_in;
    assign do_move = accept && (op == OP_MOVE) && hit;

    cam_res_tracker #(.ENTRIES(ENTRIES), .IW(IW)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (do_load),
        .vec_in    (match_vec),
        .step      (do_step),
        .hpm       (hpm_addr),
        .hit       (hit),
        .multi     (multi),
        .exhausted (exhausted)
    );

    cam_res_mask_file #(.REGS(MREGS), .W(WIDTH), .SW(SW)) u_masks (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mask_wr_en),
        .wr_sel  (mask_wr_sel),
        .wr_data (mask_wr_data),
        .rd_sel  (mask_sel_q),
        .rd_mask (mask_q)
    );

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (do_move) state_nxt = ST_FETCH;
            ST_FETCH: state_nxt = ST_MERGE;
            ST_MERGE: state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // State register, move mask select and comparand
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            mask_sel_q <= '0;
            comparand  <= '0;
        end else begin
            state <= state_nxt;
            if (do_move) mask_sel_q <= op_mask_sel;
            if (state == ST_MERGE)
                comparand <= (comparand & mask_q) | (rd_data & ~mask_q);
            else if (cmp_wr_en)
                comparand <= cmp_wr_data;
        end
    end

    // Outputs
    always_comb begin
        rd_en    = (state == ST_FETCH);
        rd_addr  = hpm_addr;
        vbus_oe  = (state == ST_IDLE);
        prio_out = prio_in | hit;
    end

    // R7: a read is issued only while a hit is held, then the merge follows
    p_read_has_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> hit);
    p_read_then_merge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (!rd_en && !vbus_oe));

    // R8: bits whose mask bit is 1 survive the merge
    p_merge_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MERGE) |=> (((comparand ^ $past(comparand)) & $past(mask_q)) == '0));

    // R11: a move without a hit starts no read
    p_move_needs_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == OP_MOVE && state == ST_IDLE && !hit) |=> (vbus_oe && !rd_en));

    // R12: a command during a move does not disturb the address
    p_busy_ignores_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(hpm_addr));
endmodule

// File: tb/cam_match_resolver_tb.sv
module cam_match_resolver_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = 2'b00;
    logic [2:0]  op_mask_sel = 3'd0;
    logic [15:0] match_vec = '0;
    logic        prio_in = 1'b0;
    logic        cmp_wr_en = 1'b0;
    logic [63:0] cmp_wr_data = '0;
    logic        mask_wr_en = 1'b0;
    logic [2:0]  mask_wr_sel = 3'd0;
    logic [63:0] mask_wr_data = '0;
    logic [63:0] rd_data = '0;
    logic        rd_en;
    logic [3:0]  rd_addr;
    logic [63:0] comparand;
    logic [3:0]  hpm_addr;
    logic        hit, multi, exhausted, prio_out, vbus_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    cam_match_resolver u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_mask_sel(op_mask_sel), .match_vec(match_vec), .prio_in(prio_in),
        .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data),
        .mask_wr_en(mask_wr_en), .mask_wr_sel(mask_wr_sel), .mask_wr_data(mask_wr_data),
        .rd_data(rd_data), .rd_en(rd_en), .rd_addr(rd_addr), .comparand(comparand),
        .hpm_addr(hpm_addr), .hit(hit), .multi(multi), .exhausted(exhausted),
        .prio_out(prio_out), .vbus_oe(vbus_oe)
    );

    function automatic logic [63:0] entry_val(input logic [3:0] k);
        logic [31:0] kk;
        kk = {28'd0, k};
        return {32'hC0DE0000 + kk * 32'h0001_0101, 32'h1357_9BDF ^ (kk * 32'h0F0F_0F0F)};
    endfunction

    function automatic logic [63:0] mask_pat(input int r);
        logic [63:0] base;
        base = 64'h0123_4567_89AB_CDEF ^ {8{8'(r * 37)}};
        return (base << (r * 5)) | (base >> (64 - r * 5));
    endfunction

    function automatic logic [3:0] lowest(input logic [15:0] v);
        for (int i = 0; i < 16; i++) if (v[i]) return 4'(i);
        return 4'd0;
    endfunction

    // Synchronous array model: one cycle latency
    always @(posedge clk) if (rd_en) rd_data <= entry_val(rd_addr);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] code, input logic [15:0] mv, input logic [2:0] ms);
        @(negedge clk);
        op_valid = 1'b1; op_code = code; match_vec = mv; op_mask_sel = ms;
        @(negedge clk);
        op_valid = 1'b0; op_code = 2'b00;
    endtask

    task automatic load_cmp(input logic [63:0] v);
        @(negedge clk); cmp_wr_en = 1'b1; cmp_wr_data = v;
        @(negedge clk); cmp_wr_en = 1'b0;
    endtask

    task automatic write_mask(input logic [2:0] s, input logic [63:0] v);
        @(negedge clk); mask_wr_en = 1'b1; mask_wr_sel = s; mask_wr_data = v;
        @(negedge clk); mask_wr_en = 1'b0;
    endtask

    logic [3:0] exp_addr = 4'd0;

    // Compare, then step through every hit and one step beyond
    task automatic walk(input logic [15:0] v);
        logic [15:0] ev;
        logic        eexh;
        ev = v; eexh = 1'b0;
        issue(2'b01, v, 3'd0);
        if (v != 0) exp_addr = lowest(v);
        chk("R2 R5 flags", {hit, multi, exhausted}, {ev != 0, $countones(ev) > 1, 1'b0});
        chk("R2 R4 addr", hpm_addr, exp_addr);
        for (int s = 0; s <= $countones(v); s++) begin
            issue(2'b10, 16'h0, 3'd0);
            if (ev != 0) begin
                ev = ev & (ev - 16'd1);
                if (ev == 0) eexh = 1'b1; else exp_addr = lowest(ev);
            end
            chk("R3 R4 flags", {hit, multi, exhausted}, {ev != 0, $countones(ev) > 1, eexh});
            chk("R3 R4 addr", hpm_addr, exp_addr);
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        logic [63:0] cbase, cexp;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", {hit, multi, exhausted, hpm_addr, rd_en, vbus_oe, prio_out},
                  {1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b1, 1'b0});
        chk("R1 comparand", comparand, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R5 sweeps
        walk(16'h0000);
        for (int i = 0; i < 16; i++) walk(16'(1) << i);
        for (int i = 0; i < 16; i++)
            for (int j = i + 1; j < 16; j++) walk((16'(1) << i) | (16'(1) << j));
        lfsr = 16'hACE1;
        for (int n = 0; n < 48; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            walk(lfsr | {lfsr[7:0], lfsr[15:8]});
        end
        walk(16'hFFFF);
        // R5: compare mid-walk replaces the held vector
        issue(2'b01, 16'h00F0, 3'd0);
        issue(2'b10, 16'h0, 3'd0);
        issue(2'b01, 16'h0300, 3'd0);
        chk("R5 reload", {hpm_addr, hit, multi, exhausted}, {4'd8, 1'b1, 1'b1, 1'b0});

        // R6 priority chain blocks steps
        issue(2'b01, 16'b1010, 3'd0);
        prio_in = 1'b1;
        @(negedge clk);
        chk("R6 prio_out high", prio_out, 1);
        issue(2'b10, 16'h0, 3'd0);
        chk("R6 step blocked", {hpm_addr, multi}, {4'd1, 1'b1});
        prio_in = 1'b0;
        @(negedge clk);
        chk("R6 prio_out hit", prio_out, 1);
        issue(2'b10, 16'h0, 3'd0);
        chk("R6 step resumes", {hpm_addr, multi}, {4'd3, 1'b0});
        issue(2'b10, 16'h0, 3'd0);
        chk("R6 prio_out idle", prio_out, 0);

        // R9: try to write register 0
        write_mask(3'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        for (int r = 1; r < 8; r++) write_mask(3'(r), mask_pat(r));

        // R7 R8 R9 R10 R13 move sweep over every mask select
        cbase = 64'hFFFF_0000_AAAA_5555;
        for (int s = 0; s < 8; s++) begin
            load_cmp(cbase ^ {8{8'(s)}});
            chk("R13 load", comparand, cbase ^ {8{8'(s)}});
            issue(2'b01, 16'(1) << (s + 3), 3'd0);
            issue(2'b11, 16'h0, 3'(s));
            chk("R7 R10 fetch", {rd_en, rd_addr, vbus_oe}, {1'b1, 4'(s + 3), 1'b0});
            @(negedge clk);
            chk("R10 merge", {rd_en, vbus_oe}, {1'b0, 1'b0});
            @(negedge clk);
            cexp = (s == 0) ? entry_val(4'(s + 3))
                 : (((cbase ^ {8{8'(s)}}) & mask_pat(s)) | (entry_val(4'(s + 3)) & ~mask_pat(s)));
            chk(s == 0 ? "R9 R7 unmasked move" : "R8 masked move", comparand, cexp);
            chk("R10 released", vbus_oe, 1);
        end

        // R11 move without hit
        load_cmp(64'h1122_3344_5566_7788);
        issue(2'b01, 16'h0000, 3'd0);
        issue(2'b11, 16'h0, 3'd0);
        chk("R11 no read", {rd_en, vbus_oe}, {1'b0, 1'b1});
        @(negedge clk); @(negedge clk);
        chk("R11 comparand kept", comparand, 64'h1122_3344_5566_7788);

        // R12 command during move ignored
        issue(2'b01, 16'b0110, 3'd0);
        issue(2'b11, 16'h0, 3'd0);
        op_valid = 1'b1; op_code = 2'b10;
        @(negedge clk);
        op_valid = 1'b1; op_code = 2'b01; match_vec = 16'h8000;
        @(negedge clk);
        op_valid = 1'b0; op_code = 2'b00;
        chk("R12 state kept", {hpm_addr, multi, hit}, {4'd1, 1'b1, 1'b1});
        chk("R12 move done", comparand, entry_val(4'd1));

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule